// File: doc/BRIEF.md
# Audio Sample Stream Formatter

This block converts between a byte-wide host data stream and a pair of 16-bit left/right converter sample ports. In the playback direction it gathers host bytes into samples, places them on the left and right channels, and hands a complete pair to the converter outputs at each sample strobe. In the capture direction it takes the converter inputs at each sample strobe and breaks them into host bytes.

Three configuration inputs set the sample layout. They are channel mode (stereo or mono), coding family (linear or companded) and a format bit. Linear data is either 8-bit offset-binary (unsigned) or 16-bit two's complement. Companded data is one byte per sample. Its expansion and compression happen outside this block. The byte is carried unchanged in the low half of the converter word, and the active law is reported on a 2-bit kind output.

Mono is handled differently in each direction. On playback, one host sample drives both channels. On capture, only the left channel reaches the host. Both host ports use valid/ready handshakes.

Top module: `audio_stream_fmt`

## Requirements
- R1: After reset, both converter outputs are zero, `pb_underrun` and `cap_valid` are low, and `pb_ready` is high.
- R2: `fmt_kind` equals {`cfg_compand`, `cfg_fmt`}: 0 is 8-bit unsigned linear, 1 is 16-bit two's-complement linear, 2 is 8-bit mu-law, 3 is 8-bit A-law.
- R3: In kind 0, a playback byte b becomes the sample {~b[7], b[6:0], 8'h00}.
- R4: In kind 1, each playback sample takes two host bytes, low byte first.
- R5: In stereo, successive playback samples go to left, then right. A complete pair appears on `pb_left`/`pb_right` in the cycle after the strobe that follows its completion.
- R6: In mono playback, each sample drives `pb_left` and `pb_right` with the same value.
- R7: A strobe that finds no complete playback pair raises `pb_underrun` for one cycle and leaves both outputs unchanged.
- R8: In kinds 2 and 3, a playback byte b becomes {8'h00, b}. Capture sends bits [7:0] of each converter sample as a single byte.
- R9: In stereo capture, the left bytes go out before the right bytes. Kind 0 sends {~s[15], s[14:8]}. Kind 1 sends s[7:0] and then s[15:8].
- R10: In mono capture, only the bytes of `cap_left` are delivered, and `cap_right` is discarded.
- R11: `cap_data` is held stable while `cap_valid` is high and `cap_ready` is low. A strobe that arrives while bytes of an earlier pair are still held discards the new pair. This includes the cycle in which the last held byte is taken.
- R12: A configuration change discards any partially assembled playback sample or pair, so the next byte starts a new left sample. It also flushes any undelivered capture bytes.
- R13: `pb_ready` is low while a complete playback pair waits for its strobe, and in the cycle a configuration change is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stereo | input | 1 | 1 = stereo, 0 = mono |
| cfg_compand | input | 1 | 1 = companded, 0 = linear |
| cfg_fmt | input | 1 | Format select within the coding family |
| fmt_kind | output | 2 | Active sample kind code |
| smp_strobe | input | 1 | One-cycle sample-rate strobe |
| pb_data | input | 8 | Playback host byte |
| pb_valid | input | 1 | Playback byte valid |
| pb_ready | output | 1 | Playback byte accepted when high with valid |
| pb_left | output | 16 | Left playback sample to converter |
| pb_right | output | 16 | Right playback sample to converter |
| pb_underrun | output | 1 | One-cycle pulse: strobe found no pair |
| cap_left | input | 16 | Left capture sample from converter |
| cap_right | input | 16 | Right capture sample from converter |
| cap_data | output | 8 | Capture host byte |
| cap_valid | output | 1 | Capture byte valid |
| cap_ready | input | 1 | Host takes capture byte when high with valid |

## Verification
The converter outputs and the underrun flag are registered once after the strobe edge, so each result is due one clock after the strobe. The bench drives inputs on the falling edge and reads results on the next falling edge. A capture byte becomes valid one cycle after its strobe and advances one cycle after each accepted handshake. The bench therefore reads each byte on the falling edge before raising ready and reads the next one a cycle later. After a configuration change, the bench waits two cycles before sending data, because the change is seen in the first cycle and acted on at the edge that ends it.

// File: rtl/asf_pkg.sv
package asf_pkg;

    localparam int BYTE_W   = 8;
    localparam int SMP_W    = 2 * BYTE_W;
    localparam int Q_DEPTH  = 4;
    localparam int Q_IDX_W  = $clog2(Q_DEPTH + 1);

    typedef enum logic [1:0] {
        KIND_U8    = 2'd0,
        KIND_S16   = 2'd1,
        KIND_MULAW = 2'd2,
        KIND_ALAW  = 2'd3
    } kind_e;

    typedef struct packed {
        logic stereo;
        logic compand;
        logic fmt;
    } cfg_t;

    typedef struct packed {
        logic [SMP_W-1:0] l;
        logic [SMP_W-1:0] r;
    } pair_t;

    typedef struct packed {
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b0;
    } split_t;

    function automatic kind_e kind_of(cfg_t c);
        return kind_e'({c.compand, c.fmt});
    endfunction

    function automatic logic is_wide(kind_e k);
        return k == KIND_S16;
    endfunction

    // Build a converter word from the byte(s) of one host sample.
    function automatic logic [SMP_W-1:0] to_sample(kind_e k, logic [BYTE_W-1:0] lo,
                                                  logic [BYTE_W-1:0] b);
        logic [SMP_W-1:0] s;
        case (k)
            KIND_U8:  s = {~b[BYTE_W-1], b[BYTE_W-2:0], {BYTE_W{1'b0}}};
            KIND_S16: s = {b, lo};
            default:  s = {{BYTE_W{1'b0}}, b};
        endcase
        return s;
    endfunction

    // Break a converter word into host byte(s); b0 goes out first.
    function automatic split_t to_bytes(kind_e k, logic [SMP_W-1:0] s);
        split_t o;
        o.b1 = s[SMP_W-1:BYTE_W];
        case (k)
            KIND_U8: o.b0 = {~s[SMP_W-1], s[SMP_W-2:BYTE_W]};
            default: o.b0 = s[BYTE_W-1:0];
        endcase
        return o;
    endfunction

endpackage

// File: rtl/asf_cfg_track.sv
module asf_cfg_track
    import asf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    output logic  cfg_chg,
    output kind_e kind
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        cfg_q <= cfg;
    end

    assign cfg_chg = !rst && (cfg != cfg_q);
    assign kind    = kind_of(cfg);

endmodule

// File: rtl/asf_unpack.sv
module asf_unpack
    import asf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  kind_e             kind,
    input  logic              flush,
    input  logic              strobe,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output pair_t             out_pair,
    output logic              underrun
);
    logic              byte_hi;
    logic              phase_r;
    logic [BYTE_W-1:0] lo_q;
    logic [SMP_W-1:0]  left_q;
    pair_t             pend;
    logic              pend_full;
    logic              accept;
    logic [SMP_W-1:0]  smp;

    assign in_ready = !pend_full && !flush;
    assign accept   = in_valid && in_ready;
    assign smp      = to_sample(kind, lo_q, in_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_hi   <= 1'b0;
            phase_r   <= 1'b0;
            lo_q      <= '0;
            left_q    <= '0;
            pend      <= '0;
            pend_full <= 1'b0;
            out_pair  <= '0;
            underrun  <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (strobe) begin
                if (pend_full) begin
                    out_pair  <= pend;
                    pend_full <= 1'b0;
                end else begin
                    underrun <= 1'b1;
                end
            end
            if (flush) begin
                byte_hi <= 1'b0;
                phase_r <= 1'b0;
            end else if (accept) begin
                if (is_wide(kind) && !byte_hi) begin
                    lo_q    <= in_data;
                    byte_hi <= 1'b1;
                end else begin
                    byte_hi <= 1'b0;
                    if (!cfg.stereo) begin
                        pend      <= '{l: smp, r: smp};
                        pend_full <= 1'b1;
                    end else if (!phase_r) begin
                        left_q  <= smp;
                        phase_r <= 1'b1;
                    end else begin
                        pend      <= '{l: left_q, r: smp};
                        pend_full <= 1'b1;
                        phase_r   <= 1'b0;
                    end
                end
            end
        end
    end

    // R7: an underrun leaves the converter outputs untouched
    a_r7_underrun_holds: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $stable(out_pair));

    // R7: underrun only follows a strobe
    a_r7_underrun_after_strobe: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $past(strobe));

    // R6: a pair completed in mono carries equal channels
    a_r6_mono_equal: assert property (@(posedge clk) disable iff (rst)
        ($rose(pend_full) && !$past(cfg.stereo)) |-> (pend.l == pend.r));

endmodule

// File: rtl/asf_pack.sv
module asf_pack
    import asf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  kind_e             kind,
    input  logic              flush,
    input  logic              strobe,
    input  logic [SMP_W-1:0]  in_left,
    input  logic [SMP_W-1:0]  in_right,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    logic [Q_DEPTH-1:0][BYTE_W-1:0] q;
    logic [Q_DEPTH-1:0][BYTE_W-1:0] q_n;
    logic [Q_IDX_W-1:0]             cnt;
    logic [Q_IDX_W-1:0]             cnt_n;
    logic [Q_IDX_W-1:0]             idx;
    split_t                         lb;
    split_t                         rb;

    assign lb = to_bytes(kind, in_left);
    assign rb = to_bytes(kind, in_right);

    always_comb begin
        q_n = '0;
        q_n[0] = lb.b0;
        if (is_wide(kind)) begin
            q_n[1] = lb.b1;
            q_n[2] = rb.b0;
            q_n[3] = rb.b1;
        end else begin
            q_n[1] = rb.b0;
        end
        cnt_n = Q_IDX_W'((is_wide(kind) ? 2 : 1) * (cfg.stereo ? 2 : 1));
    end

    assign out_valid = (cnt != '0);
    assign out_data  = q[idx[1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            cnt <= '0;
            idx <= '0;
        end else begin
            if (flush) begin
                cnt <= '0;
                idx <= '0;
            end else if (out_valid && out_ready) begin
                if (idx == cnt - 1'b1) begin
                    cnt <= '0;
                    idx <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (strobe && (cnt == '0 || flush)) begin
                q   <= q_n;
                cnt <= cnt_n;
                idx <= '0;
            end
        end
    end

    // R11: a stalled byte stays on the port
    a_r11_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

    // R9: the queue never claims more bytes than one stereo 16-bit pair
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        (cnt <= Q_IDX_W'(Q_DEPTH)) && (idx < Q_IDX_W'(Q_DEPTH)));

endmodule

// File: rtl/audio_stream_fmt.sv
module audio_stream_fmt
    import asf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_stereo,
    input  logic        cfg_compand,
    input  logic        cfg_fmt,
    output logic [1:0]  fmt_kind,
    input  logic        smp_strobe,
    input  logic [7:0]  pb_data,
    input  logic        pb_valid,
    output logic        pb_ready,
    output logic [15:0] pb_left,
    output logic [15:0] pb_right,
    output logic        pb_underrun,
    input  logic [15:0] cap_left,
    input  logic [15:0] cap_right,
    output logic [7:0]  cap_data,
    output logic        cap_valid,
    input  logic        cap_ready
);
    cfg_t  cfg;
    kind_e kind;
    logic  chg;
    pair_t pb_pair;

    assign cfg = '{stereo: cfg_stereo, compand: cfg_compand, fmt: cfg_fmt};

    asf_cfg_track u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .cfg_chg (chg),
        .kind    (kind)
    );

    asf_unpack u_unpack (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .kind     (kind),
        .flush    (chg),
        .strobe   (smp_strobe),
        .in_data  (pb_data),
        .in_valid (pb_valid),
        .in_ready (pb_ready),
        .out_pair (pb_pair),
        .underrun (pb_underrun)
    );

    asf_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .kind      (kind),
        .flush     (chg),
        .strobe    (smp_strobe),
        .in_left   (cap_left),
        .in_right  (cap_right),
        .out_data  (cap_data),
        .out_valid (cap_valid),
        .out_ready (cap_ready)
    );

    assign fmt_kind = kind;
    assign pb_left  = pb_pair.l;
    assign pb_right = pb_pair.r;

    // R13: no host byte is taken in a configuration-change cycle
    a_r13_no_accept_on_change: assert property (@(posedge clk) disable iff (rst)
        chg |-> !pb_ready);

endmodule

// File: tb/audio_stream_fmt_tb.sv
module audio_stream_fmt_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_stereo = 1'b0, cfg_compand = 1'b0, cfg_fmt = 1'b0;
    logic [1:0]  fmt_kind;
    logic        smp_strobe = 1'b0;
    logic [7:0]  pb_data = '0;
    logic        pb_valid = 1'b0;
    logic        pb_ready;
    logic [15:0] pb_left, pb_right;
    logic        pb_underrun;
    logic [15:0] cap_left = '0, cap_right = '0;
    logic [7:0]  cap_data;
    logic        cap_valid;
    logic        cap_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_stream_fmt u_dut (
        .clk(clk), .rst(rst),
        .cfg_stereo(cfg_stereo), .cfg_compand(cfg_compand), .cfg_fmt(cfg_fmt),
        .fmt_kind(fmt_kind), .smp_strobe(smp_strobe),
        .pb_data(pb_data), .pb_valid(pb_valid), .pb_ready(pb_ready),
        .pb_left(pb_left), .pb_right(pb_right), .pb_underrun(pb_underrun),
        .cap_left(cap_left), .cap_right(cap_right),
        .cap_data(cap_data), .cap_valid(cap_valid), .cap_ready(cap_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic s, input logic c, input logic f);
        @(negedge clk);
        cfg_stereo = s; cfg_compand = c; cfg_fmt = f;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        pb_data = b; pb_valid = 1'b1;
        while (!pb_ready) @(negedge clk);
        @(negedge clk);
        pb_valid = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        cap_left = l; cap_right = r; smp_strobe = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
    endtask

    task automatic get_byte(input string req, input logic [7:0] exp);
        check({req, " valid"}, 32'(cap_valid), 32'd1);
        check(req, 32'(cap_data), 32'(exp));
        cap_ready = 1'b1;
        @(negedge clk);
        cap_ready = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 8 && cap_valid; i++) begin
            cap_ready = 1'b1;
            @(negedge clk);
        end
        cap_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 left", 32'(pb_left), 32'h0);
        check("R1 right", 32'(pb_right), 32'h0);
        check("R1 underrun", 32'(pb_underrun), 32'h0);
        check("R1 cap_valid", 32'(cap_valid), 32'h0);
        check("R1 pb_ready", 32'(pb_ready), 32'h1);
    endtask

    task automatic t_kind();
        for (int k = 0; k < 4; k++) begin
            set_cfg(1'b1, k[1], k[0]);
            check("R2 kind", 32'(fmt_kind), 32'(k));
        end
    endtask

    task automatic t_underrun_first();
        pulse(16'h0, 16'h0);
        check("R7 underrun", 32'(pb_underrun), 32'h1);
        check("R7 left held", 32'(pb_left), 32'h0);
        @(negedge clk);
        check("R7 one cycle", 32'(pb_underrun), 32'h0);
        drain();
    endtask

    task automatic t_u8_stereo();
        set_cfg(1'b1, 1'b0, 1'b0);
        send_byte(8'hC3);
        send_byte(8'h12);
        pulse(16'h0, 16'h0);
        check("R3 R5 left", 32'(pb_left), 32'h4300);
        check("R3 R5 right", 32'(pb_right), 32'h9200);
        check("R5 no underrun", 32'(pb_underrun), 32'h0);
        pulse(16'h0, 16'h0);
        check("R7 underrun repeat", 32'(pb_underrun), 32'h1);
        check("R7 left repeat", 32'(pb_left), 32'h4300);
        check("R7 right repeat", 32'(pb_right), 32'h9200);
        drain();
    endtask

    task automatic t_s16_stereo();
        set_cfg(1'b1, 1'b0, 1'b1);
        send_byte(8'h34); send_byte(8'h12);
        send_byte(8'h78); send_byte(8'h56);
        pulse(16'h0, 16'h0);
        check("R4 left", 32'(pb_left), 32'h1234);
        check("R4 right", 32'(pb_right), 32'h5678);
        drain();
    endtask

    task automatic t_mono_play();
        set_cfg(1'b0, 1'b0, 1'b0);
        send_byte(8'hFF);
        pulse(16'h0, 16'h0);
        check("R6 u8 left", 32'(pb_left), 32'h7F00);
        check("R6 u8 right", 32'(pb_right), 32'h7F00);
        set_cfg(1'b0, 1'b0, 1'b1);
        send_byte(8'hCD); send_byte(8'hAB);
        pulse(16'h0, 16'h0);
        check("R6 s16 left", 32'(pb_left), 32'hABCD);
        check("R6 s16 right", 32'(pb_right), 32'hABCD);
        drain();
    endtask

    task automatic t_companded();
        set_cfg(1'b0, 1'b1, 1'b0);
        send_byte(8'h5A);
        pulse(16'h0, 16'h0);
        check("R8 mulaw left", 32'(pb_left), 32'h005A);
        check("R8 mulaw right", 32'(pb_right), 32'h005A);
        set_cfg(1'b1, 1'b1, 1'b1);
        send_byte(8'h11); send_byte(8'h22);
        pulse(16'h0, 16'h0);
        check("R8 alaw left", 32'(pb_left), 32'h0011);
        check("R8 alaw right", 32'(pb_right), 32'h0022);
        drain();
        pulse(16'h00A5, 16'hFF3C);
        get_byte("R8 cap left", 8'hA5);
        get_byte("R8 cap right", 8'h3C);
        check("R8 cap done", 32'(cap_valid), 32'h0);
    endtask

    task automatic t_capture();
        set_cfg(1'b1, 1'b0, 1'b0);
        pulse(16'h1234, 16'hF0F0);
        get_byte("R9 u8 left", 8'h92);
        get_byte("R9 u8 right", 8'h70);
        check("R9 u8 done", 32'(cap_valid), 32'h0);
        set_cfg(1'b1, 1'b0, 1'b1);
        drain();
        pulse(16'h1234, 16'hABCD);
        get_byte("R9 s16 b0", 8'h34);
        get_byte("R9 s16 b1", 8'h12);
        get_byte("R9 s16 b2", 8'hCD);
        get_byte("R9 s16 b3", 8'hAB);
        check("R9 s16 done", 32'(cap_valid), 32'h0);
    endtask

    task automatic t_capture_mono();
        set_cfg(1'b0, 1'b0, 1'b1);
        drain();
        pulse(16'hBEEF, 16'h1111);
        get_byte("R10 s16 lo", 8'hEF);
        get_byte("R10 s16 hi", 8'hBE);
        check("R10 right dropped", 32'(cap_valid), 32'h0);
        set_cfg(1'b0, 1'b0, 1'b0);
        drain();
        pulse(16'h0000, 16'hFFFF);
        get_byte("R10 u8", 8'h80);
        check("R10 u8 right dropped", 32'(cap_valid), 32'h0);
    endtask

    task automatic t_hold_discard();
        set_cfg(1'b0, 1'b0, 1'b1);
        drain();
        pulse(16'h1111, 16'h0);
        repeat (3) @(negedge clk);
        check("R11 held data", 32'(cap_data), 32'h11);
        pulse(16'h2222, 16'h0);
        get_byte("R11 first b0", 8'h11);
        get_byte("R11 first b1", 8'h11);
        check("R11 second dropped", 32'(cap_valid), 32'h0);
    endtask

    task automatic t_cfg_change();
        set_cfg(1'b1, 1'b0, 1'b1);
        drain();
        send_byte(8'h34); send_byte(8'h12); send_byte(8'h99);
        set_cfg(1'b0, 1'b0, 1'b0);
        set_cfg(1'b1, 1'b0, 1'b1);
        send_byte(8'h78); send_byte(8'h56);
        send_byte(8'hBC); send_byte(8'h9A);
        pulse(16'h0102, 16'h0304);
        check("R12 left restart", 32'(pb_left), 32'h5678);
        check("R12 right restart", 32'(pb_right), 32'h9ABC);
        get_byte("R12 cap first", 8'h02);
        @(negedge clk);
        cfg_stereo = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R12 cap flushed", 32'(cap_valid), 32'h0);
    endtask

    task automatic t_ready_block();
        set_cfg(1'b0, 1'b0, 1'b0);
        send_byte(8'h01);
        check("R13 ready low", 32'(pb_ready), 32'h0);
        @(negedge clk);
        cfg_fmt = 1'b1;
        check("R13 ready low on change", 32'(pb_ready), 32'h0);
        @(negedge clk);
        cfg_fmt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pulse(16'h0, 16'h0);
        check("R13 ready back", 32'(pb_ready), 32'h1);
        check("R13 pair out", 32'(pb_left), 32'h8100);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_underrun_first();
        t_kind();
        t_u8_stereo();
        t_s16_stereo();
        t_mono_play();
        t_companded();
        t_capture();
        t_capture_mono();
        t_hold_discard();
        t_cfg_change();
        t_ready_block();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule